// File: doc/BRIEF.md
# Cross-Product Transfer Parameter Sequencer

The sequencer holds four short programmable lists of transfer parameters: block size in bytes, start offset within a quadword, address-phase byte-enable pattern, and bus command code. A request strobe produces one parameter tuple. Successive strobes walk the lists as a mixed-radix counter, so one pass yields every combination of the active entries exactly once, with no repeats. The number of combinations in a pass is known before the first request.

A host first fills the lists through a write port while the sequencer is idle. It then sets the active length of each list and pulses `start`. The sequencer returns the pass length on `total_combos`. From then on, each `req` returns a tuple one cycle later. The tuple that closes a pass is flagged by `wrap`, and `pass_count` advances with it. A `stop` pulse returns the sequencer to idle so that the lists can be rewritten. The transfers themselves are issued by other logic.

Top module: `perm_engine`

## Requirements
- R1: After reset, `running`, `out_valid` and `wrap` are 0, and `pass_count` and `total_combos` are 0.
- R2: List-select codes are 0 for size, 1 for offset, 2 for byte enables and 3 for command. Entry and length writes are accepted only while `running` is 0. Writes made while running leave both the entries and the lengths unchanged. A length write above the list depth (100) is ignored.
- R3: In the cycle after `start`, `running` is 1 and `total_combos` equals the product of the four active lengths, with a length of 0 counted as 1.
- R4: Each `req` seen while running and without `start` gives `out_valid` high for one cycle, in the cycle after the strobe. A `req` while idle gives no `out_valid`.
- R5: The size list advances on every accepted request. The offset, byte-enable and command lists each advance only when all lower lists wrap together. The tuple for request k therefore uses size index k mod Ls, offset index (k/Ls) mod La, byte-enable index (k/(Ls·La)) mod Lb and command index (k/(Ls·La·Lb)) mod Lc.
- R6: `out_size` is the stored size rounded up to the next multiple of 8 bytes. For stored values from 1 to 4096, it is never 0.
- R7: `wrap` is high together with `out_valid` exactly on the last tuple of a pass, and `pass_count` is one higher in that same cycle. The next tuple is the first tuple of the pass again.
- R8: A list with active length 0 supplies one default entry: size 8, offset 0, byte enables 4'hF, command 4'h7.
- R9: `start` while running restarts the walk from the first tuple, clears `pass_count` and recomputes `total_combos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| ent_we | input | 1 | Write one list entry |
| len_we | input | 1 | Write one list's active length |
| wr_list | input | 2 | List select for either write |
| wr_idx | input | 7 | Entry index |
| wr_data | input | 13 | Entry value, low bits used for the narrower lists |
| wr_len | input | 7 | Active length value |
| start | input | 1 | Compute the pass length and begin or restart the walk |
| stop | input | 1 | Return to idle |
| req | input | 1 | Next-tuple strobe |
| running | output | 1 | Walk in progress, lists locked |
| total_combos | output | 28 | Combinations per pass |
| out_valid | output | 1 | Tuple valid pulse |
| out_size | output | 13 | Quadword-rounded block size |
| out_align | output | 3 | Start offset within quadword |
| out_be | output | 4 | Byte-enable pattern |
| out_cmd | output | 4 | Bus command code |
| wrap | output | 1 | Last tuple of a pass |
| pass_count | output | 16 | Completed passes since start |

## Verification
A corrupted digit index shows up at once: the next tuple carries a wrong field, because every tuple's position in the walk is fixed by the request count. A carry that fires early or late shifts a higher field and moves `wrap` away from request number `total_combos`. Both errors are visible within one pass. A lock failure shows on the first tuple after a restart, as a changed entry or a changed `total_combos`.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int NLISTS = 4;
  typedef enum logic [1:0] {
    LIST_SIZE  = 2'd0,
    LIST_ALIGN = 2'd1,
    LIST_BE    = 2'd2,
    LIST_CMD   = 2'd3
  } list_sel_e;
endpackage

// File: rtl/perm_list.sv
module perm_list #(
  parameter int DEPTH = 100,
  parameter int W = 4,
  parameter int IDX_W = 7,
  parameter int LEN_W = 7,
  parameter logic [W-1:0] DEFAULT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             we_ent,
  input  logic             we_len,
  input  logic [IDX_W-1:0] idx_wr,
  input  logic [W-1:0]     data_wr,
  input  logic [LEN_W-1:0] len_wr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [LEN_W-1:0] eff_len
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [LEN_W-1:0] len_q, len_d;
  logic             ent_ok;

  assign ent_ok = we_ent && !lock && ({1'b0, idx_wr} < (IDX_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (ent_ok) mem_q[idx_wr] <= data_wr;
  end

  always_comb begin
    len_d = len_q;
    if (we_len && !lock && (len_wr <= LEN_W'(DEPTH))) len_d = len_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign eff_len = (len_q == '0) ? LEN_W'(1) : len_q;
  assign rd_data = (len_q == '0) ? DEFAULT : mem_q[rd_idx];

  assert_len_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(len_q));
endmodule

// File: rtl/perm_digit.sv
module perm_digit #(
  parameter int IDX_W = 7,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] eff_len,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] idx_d;

  assign last = (LEN_W'(idx) + LEN_W'(1)) == eff_len;

  always_comb begin
    idx_d = idx;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = last ? '0 : idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end

  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (LEN_W'(idx) < eff_len));
endmodule

// File: rtl/perm_engine.sv
module perm_engine #(
  parameter int DEPTH = 100,
  parameter int SIZE_W = 13,
  parameter int ALIGN_W = 3,
  parameter int BE_W = 4,
  parameter int CMD_W = 4,
  parameter int PASS_W = 16,
  parameter int DEF_SIZE = 8,
  parameter int DEF_ALIGN = 0,
  parameter int DEF_BE = 15,
  parameter int DEF_CMD = 7,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int TOT_W = perm_pkg::NLISTS * LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_we,
  input  logic              len_we,
  input  logic [1:0]        wr_list,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SIZE_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              start,
  input  logic              stop,
  input  logic              req,
  output logic              running,
  output logic [TOT_W-1:0]  total_combos,
  output logic              out_valid,
  output logic [SIZE_W-1:0] out_size,
  output logic [ALIGN_W-1:0] out_align,
  output logic [BE_W-1:0]   out_be,
  output logic [CMD_W-1:0]  out_cmd,
  output logic              wrap,
  output logic [PASS_W-1:0] pass_count
);
  localparam int NL = perm_pkg::NLISTS;

  logic [SIZE_W-1:0]  rd_size;
  logic [ALIGN_W-1:0] rd_align;
  logic [BE_W-1:0]    rd_be;
  logic [CMD_W-1:0]   rd_cmd;
  logic [LEN_W-1:0]   eff_w [NL];
  logic [IDX_W-1:0]   idx_w [NL];
  logic [NL-1:0]      last_w;
  logic [NL:0]        carry;
  logic               fire;

  assign fire     = req && running && !start;
  assign carry[0] = fire;

  for (genvar g = 0; g < NL; g++) begin : g_list
    localparam int LW = (g == 0) ? SIZE_W : (g == 1) ? ALIGN_W : (g == 2) ? BE_W : CMD_W;
    localparam int DV = (g == 0) ? DEF_SIZE : (g == 1) ? DEF_ALIGN : (g == 2) ? DEF_BE : DEF_CMD;
    logic [LW-1:0] rd_g;

    perm_list #(.DEPTH(DEPTH), .W(LW), .IDX_W(IDX_W), .LEN_W(LEN_W), .DEFAULT(LW'(DV))) list_i (
      .clk(clk), .rst_n(rst_n), .lock(running),
      .we_ent(ent_we && (wr_list == 2'(g))),
      .we_len(len_we && (wr_list == 2'(g))),
      .idx_wr(wr_idx), .data_wr(wr_data[LW-1:0]), .len_wr(wr_len),
      .rd_idx(idx_w[g]), .rd_data(rd_g), .eff_len(eff_w[g])
    );

    perm_digit #(.IDX_W(IDX_W), .LEN_W(LEN_W)) digit_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .inc(carry[g]),
      .eff_len(eff_w[g]), .idx(idx_w[g]), .last(last_w[g])
    );

    assign carry[g+1] = carry[g] && last_w[g];

    if (g == 0) begin : g_sz
      assign rd_size = rd_g;
    end else if (g == 1) begin : g_al
      assign rd_align = rd_g;
    end else if (g == 2) begin : g_be
      assign rd_be = rd_g;
    end else begin : g_cm
      assign rd_cmd = rd_g;
    end
  end

  logic              running_d, out_valid_d, wrap_d;
  logic [TOT_W-1:0]  total_d;
  logic [PASS_W-1:0] pass_d;
  logic [SIZE_W-1:0] size_d;
  logic [ALIGN_W-1:0] align_d;
  logic [BE_W-1:0]   be_d;
  logic [CMD_W-1:0]  cmd_d;

  always_comb begin
    running_d   = running;
    total_d     = total_combos;
    pass_d      = pass_count;
    out_valid_d = fire;
    wrap_d      = fire && carry[NL];
    size_d      = out_size;
    align_d     = out_align;
    be_d        = out_be;
    cmd_d       = out_cmd;
    if (start) begin
      running_d = 1'b1;
      pass_d    = '0;
      total_d   = TOT_W'(eff_w[0]) * TOT_W'(eff_w[1]) * TOT_W'(eff_w[2]) * TOT_W'(eff_w[3]);
    end else if (stop) begin
      running_d = 1'b0;
    end
    if (fire) begin
      size_d  = (rd_size + SIZE_W'(7)) & ~SIZE_W'(7);
      align_d = rd_align;
      be_d    = rd_be;
      cmd_d   = rd_cmd;
      if (carry[NL]) pass_d = pass_count + PASS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running      <= 1'b0;
      total_combos <= '0;
      pass_count   <= '0;
      out_valid    <= 1'b0;
      wrap         <= 1'b0;
      out_size     <= '0;
      out_align    <= '0;
      out_be       <= '0;
      out_cmd      <= '0;
    end else begin
      running      <= running_d;
      total_combos <= total_d;
      pass_count   <= pass_d;
      out_valid    <= out_valid_d;
      wrap         <= wrap_d;
      out_size     <= size_d;
      out_align    <= align_d;
      out_be       <= be_d;
      out_cmd      <= cmd_d;
    end
  end

  assert_valid_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req && running));
  assert_size_qword_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size[2:0] == 3'd0 && out_size != '0));
  assert_wrap_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> out_valid);
  assert_pass_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (pass_count == $past(pass_count) + PASS_W'(1)));
  assert_total_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (total_combos != '0));
endmodule

// File: tb/perm_engine_tb_top.sv
module perm_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ent_we, len_we, start, stop, req;
  logic [1:0]  wr_list;
  logic [6:0]  wr_idx, wr_len;
  logic [12:0] wr_data;
  logic        running, out_valid, wrap;
  logic [27:0] total_combos;
  logic [12:0] out_size;
  logic [2:0]  out_align;
  logic [3:0]  out_be, out_cmd;
  logic [15:0] pass_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perm_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .len_we(len_we), .wr_list(wr_list),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_len(wr_len), .start(start), .stop(stop),
    .req(req), .running(running), .total_combos(total_combos), .out_valid(out_valid),
    .out_size(out_size), .out_align(out_align), .out_be(out_be), .out_cmd(out_cmd),
    .wrap(wrap), .pass_count(pass_count)
  );

  localparam logic [12:0] SIZES [3] = '{13'd1, 13'd9, 13'd4096};
  localparam logic [12:0] ROUND [3] = '{13'd8, 13'd16, 13'd4096};
  localparam logic [2:0]  ALIGNS [2] = '{3'd0, 3'd5};
  localparam logic [3:0]  BES [2]    = '{4'hF, 4'h3};
  localparam logic [3:0]  CMDS [2]   = '{4'h6, 4'h7};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input logic [1:0] l, input logic [6:0] i, input logic [12:0] d);
    @(negedge clk); ent_we = 1; wr_list = l; wr_idx = i; wr_data = d;
    @(negedge clk); ent_we = 0;
  endtask

  task automatic wr_ln(input logic [1:0] l, input logic [6:0] n);
    @(negedge clk); len_we = 1; wr_list = l; wr_len = n;
    @(negedge clk); len_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_req();
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
  endtask

  function automatic logic [23:0] tup(input logic [12:0] s, input logic [2:0] a,
                                     input logic [3:0] b, input logic [3:0] c);
    return {s, a, b, c};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ent_we = 0; len_we = 0; start = 0; stop = 0; req = 0;
    wr_list = 0; wr_idx = 0; wr_data = 0; wr_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!running && !out_valid && !wrap, "R1 flags", {running, out_valid, wrap}, 0);
    chk(pass_count == 0, "R1 pass_count", pass_count, 0);
    chk(total_combos == 0, "R1 total", total_combos, 0);

    // R4 request while idle
    do_req();
    chk(!out_valid, "R4 idle req", out_valid, 0);

    // load lists from the table
    for (int i = 0; i < 3; i++) wr_ent(2'd0, 7'(i), SIZES[i]);
    for (int i = 0; i < 2; i++) wr_ent(2'd1, 7'(i), 13'(ALIGNS[i]));
    for (int i = 0; i < 2; i++) wr_ent(2'd2, 7'(i), 13'(BES[i]));
    for (int i = 0; i < 2; i++) wr_ent(2'd3, 7'(i), 13'(CMDS[i]));
    wr_ln(2'd0, 7'd3); wr_ln(2'd1, 7'd2); wr_ln(2'd2, 7'd2); wr_ln(2'd3, 7'd2);
    wr_ln(2'd0, 7'd101); // R2 above depth, ignored
    pulse_start();
    chk(running, "R3 running", running, 1);
    chk(total_combos == 24, "R3 R2 total", total_combos, 24);

    // R5 R6 R7 full pass walk
    for (int k = 0; k < 24; k++) begin
      logic [23:0] exp;
      exp = tup(ROUND[k % 3], ALIGNS[(k / 3) % 2], BES[(k / 6) % 2], CMDS[(k / 12) % 2]);
      do_req();
      chk(out_valid, "R4 valid", out_valid, 1);
      chk(tup(out_size, out_align, out_be, out_cmd) == exp, "R5 R6 tuple",
          tup(out_size, out_align, out_be, out_cmd), exp);
      chk(wrap == (k == 23), "R7 wrap", wrap, k == 23);
      chk(pass_count == ((k == 23) ? 1 : 0), "R7 pass_count", pass_count, (k == 23) ? 1 : 0);
      @(negedge clk);
      chk(!out_valid, "R4 one-cycle valid", out_valid, 0);
    end
    do_req();
    chk(tup(out_size, out_align, out_be, out_cmd) == tup(13'd8, 3'd0, 4'hF, 4'h6),
        "R7 restart tuple", tup(out_size, out_align, out_be, out_cmd), tup(13'd8, 3'd0, 4'hF, 4'h6));
    chk(!wrap, "R7 no wrap", wrap, 0);

    // R2 writes while running ignored; R9 restart
    wr_ent(2'd0, 7'd0, 13'd100);
    wr_ln(2'd1, 7'd1);
    do_req();
    pulse_start();
    chk(total_combos == 24, "R2 locked len", total_combos, 24);
    chk(pass_count == 0, "R9 pass cleared", pass_count, 0);
    do_req();
    chk(out_size == 13'd8 && out_align == 3'd0, "R2 R9 first entry", {out_size, out_align}, {13'd8, 3'd0});

    // R4 stop
    pulse_stop();
    chk(!running, "R4 stopped", running, 0);
    do_req();
    chk(!out_valid, "R4 req after stop", out_valid, 0);

    // R8 default entries
    wr_ln(2'd2, 7'd0); wr_ln(2'd3, 7'd0);
    pulse_start();
    chk(total_combos == 6, "R8 R3 total", total_combos, 6);
    do_req();
    chk(out_be == 4'hF && out_cmd == 4'h7, "R8 default be cmd", {out_be, out_cmd}, {4'hF, 4'h7});
    pulse_stop();
    wr_ln(2'd0, 7'd0); wr_ln(2'd1, 7'd0);
    pulse_start();
    chk(total_combos == 1, "R8 total one", total_combos, 1);
    do_req();
    chk(wrap && out_size == 13'd8 && out_align == 0, "R8 R7 single tuple", {wrap, out_size, out_align}, {1'b1, 13'd8, 3'd0});
    do_req();
    chk(wrap && pass_count == 2, "R7 back-to-back wrap", {wrap, pass_count}, {1'b1, 16'd2});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule